// File: doc/BRIEF.md
# Slave Clock Speed-Mode Auto Detector

This block sits beside an audio converter's serial port while the converter takes its clocks from outside. It is clocked by the master clock and samples the frame clock, the bit clock and a strobe from a free-running reference timer. Over every frame it counts master-clock cycles, bit-clock rising edges and reference strobes. From these counts it works out whether the link runs at single, double or quad speed, and whether the prescaler must use the fast or the slow divide ratio. No mode pins are needed to select the speed.

A master-clock ratio of 384 or 192 cycles per frame is legal at two different speeds. The block tells these cases apart by the frame period, measured in reference strobes and compared against bands derived from the reference rate. A classification is published only after it has repeated over several frames. Any clocking outside the supported set raises an error flag.

Top module: `spd_autodet`

## Requirements
- R1: When `mode` is not 2'b11, detection is idle. Within three clock cycles of the change, `locked`, `speed`, `ratio_fast` and `clk_err` are all 0, and no earlier measurement carries over.
- R2: A frame of 768±2 master cycles whose length is 64 to 74 reference strobes (about 43–50 kHz at the default 3.2 MHz reference) is classified as single speed with the fast ratio. `speed` uses 01 for single, 10 for double, 11 for quad and 00 for none.
- R3: A frame of 384±2 cycles is single speed with the slow ratio when it lasts at least 64 strobes (64 itself included), up to 1600. It is double speed with the fast ratio when it lasts 32 to 37 strobes. Any other length is an error.
- R4: A frame of 192±2 cycles is double speed with the slow ratio when it lasts 32 to 64 strobes (64 included). It is quad speed with the fast ratio when it lasts 16 to 18 strobes. Any other length is an error.
- R5: Any frame length not within ±2 of 768, 384 or 192 is an error, and this includes 96. An error result sets `clk_err` and clears `locked`.
- R6: A single-speed frame must hold exactly 48 or 64 bit-clock rising edges. A double- or quad-speed frame must hold exactly 48. Any other count is an error.
- R7: `locked` rises only after the same classification has come from 4 consecutive frames. `speed` and `ratio_fast` show the class only while `locked` is 1, and are 0 otherwise.
- R8: While locked, one frame with a different valid class leaves every output unchanged. A second consecutive such frame drops `locked`, and that frame becomes the first of a new run.
- R9: Once a measurement is running, 1536 master cycles without a frame-clock rising edge produce an error result, and a new measurement window starts.
- R10: The first frame-clock rising edge after reset, or after entering slave mode, only starts a measurement and produces no result.
- R11: `clk_err` follows the most recent result: a valid frame clears it, and `locked` and `clk_err` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all sampling and counting |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Mode pins; 2'b11 selects clock-slave auto detection |
| lrck | input | 1 | Frame clock, rising edge starts a frame |
| sclk | input | 1 | Bit clock |
| ref_tick | input | 1 | One-cycle strobe from the reference timer |
| speed | output | 2 | Detected speed: 00 none, 01 single, 10 double, 11 quad |
| ratio_fast | output | 1 | 1 for the fast divide ratio (768, 384 double, 192 quad) |
| locked | output | 1 | Classification stable |
| clk_err | output | 1 | Latest frame was unsupported clocking |

## Verification
The bench drives frames that land exactly on the 64-strobe boundary at both the 384 and the 192 ratio. A design that placed the band edge on the wrong side would return the other speed, or an error, for these frames. Frames of 770 and 771 cycles test the ratio window: an off-by-one tolerance either fails to lock or accepts bad clocks. A 64-edge bit clock at quad speed tests that the legal bit-clock count depends on the speed, and would not flag an error if that check were shared across speeds. A single mismatching frame followed by a second one checks the hysteresis: a design that dropped lock too early would show the error on the first frame, and one that never dropped it would keep stale speed outputs. A stopped frame clock must trigger the timeout, and a design without it would stay silently locked.

// File: rtl/spd_autodet_pkg.sv
package spd_autodet_pkg;

   typedef enum logic [1:0] {
      SPD_NONE   = 2'b00,
      SPD_SINGLE = 2'b01,
      SPD_DOUBLE = 2'b10,
      SPD_QUAD   = 2'b11
   } speed_e;

   typedef struct packed {
      logic   err;
      speed_e spd;
      logic   fast;
   } frame_class_t;

endpackage

// File: rtl/spd_autodet_meas.sv
module spd_autodet_meas #(
   parameter int TMO_CYC = 1536,
   parameter int CW      = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          slave_req,
   input  logic          lrck,
   input  logic          sclk,
   input  logic          ref_tick,
   output logic          done,
   output logic          tmo,
   output logic          idle,
   output logic [CW-1:0] m_len,
   output logic [CW-1:0] s_len,
   output logic [CW-1:0] r_len
);

   logic slave_q, lrck_q, lrck_q2, sclk_q, sclk_q2, ref_q;
   logic armed;
   logic [CW-1:0] mcnt, scnt, rcnt;
   logic rise, srise;

   assign rise  = lrck_q & ~lrck_q2;
   assign srise = sclk_q & ~sclk_q2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slave_q <= 1'b0;
         lrck_q  <= 1'b0;
         lrck_q2 <= 1'b0;
         sclk_q  <= 1'b0;
         sclk_q2 <= 1'b0;
         ref_q   <= 1'b0;
      end else begin
         slave_q <= slave_req;
         lrck_q  <= lrck;
         lrck_q2 <= lrck_q;
         sclk_q  <= sclk;
         sclk_q2 <= sclk_q;
         ref_q   <= ref_tick;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         done  <= 1'b0;
         tmo   <= 1'b0;
         idle  <= 1'b1;
         mcnt  <= '0;
         scnt  <= '0;
         rcnt  <= '0;
         m_len <= '0;
         s_len <= '0;
         r_len <= '0;
      end else begin
         done <= 1'b0;
         tmo  <= 1'b0;
         idle <= ~slave_q;
         if (!slave_q) begin
            armed <= 1'b0;
            mcnt  <= '0;
            scnt  <= '0;
            rcnt  <= '0;
         end else if (rise) begin
            if (armed) begin
               done  <= 1'b1;
               m_len <= mcnt;
               s_len <= scnt;
               r_len <= rcnt;
            end
            armed <= 1'b1;
            mcnt  <= CW'(1);
            scnt  <= CW'(srise);
            rcnt  <= CW'(ref_q);
         end else if (armed) begin
            if (mcnt == CW'(TMO_CYC)) begin
               done <= 1'b1;
               tmo  <= 1'b1;
               mcnt <= CW'(1);
               scnt <= CW'(srise);
               rcnt <= CW'(ref_q);
            end else begin
               mcnt <= mcnt + CW'(1);
               scnt <= scnt + CW'(srise);
               rcnt <= rcnt + CW'(ref_q);
            end
         end
      end
   end

   // R9
   mcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mcnt <= CW'(TMO_CYC));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slave_q |=> !done);

   // R10
   first_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slave_q && rise && !armed) |=> !done);

endmodule

// File: rtl/spd_autodet_class.sv
module spd_autodet_class
   import spd_autodet_pkg::*;
#(
   parameter int CW         = 11,
   parameter int BASE_RATIO = 768,
   parameter int REF_KHZ    = 3200,
   parameter int TOL        = 2
) (
   input  logic [CW-1:0] m_len,
   input  logic [CW-1:0] s_len,
   input  logic [CW-1:0] r_len,
   input  logic          tmo,
   output frame_class_t  res
);

   localparam int R_HI  = BASE_RATIO;
   localparam int R_MID = BASE_RATIO / 2;
   localparam int R_LO  = BASE_RATIO / 4;
   localparam int T2    = REF_KHZ / 2;
   localparam int T43   = REF_KHZ / 43;
   localparam int T50   = REF_KHZ / 50;
   localparam int T86   = REF_KHZ / 86;
   localparam int T100  = REF_KHZ / 100;
   localparam int T172  = REF_KHZ / 172;
   localparam int T200  = REF_KHZ / 200;
   localparam int SC_A  = 48;
   localparam int SC_B  = 64;

   function automatic logic in_win(input logic [CW-1:0] x, input int nom);
      int v;
      v = int'(x);
      return (v >= nom - TOL) && (v <= nom + TOL);
   endfunction

   logic hit_hi, hit_mid, hit_lo;

   generate
      if (TOL == 0) begin : g_exact
         assign hit_hi  = (m_len == CW'(R_HI));
         assign hit_mid = (m_len == CW'(R_MID));
         assign hit_lo  = (m_len == CW'(R_LO));
      end else begin : g_window
         assign hit_hi  = in_win(m_len, R_HI);
         assign hit_mid = in_win(m_len, R_MID);
         assign hit_lo  = in_win(m_len, R_LO);
      end
   endgenerate

   logic sc_a, sc_b;
   assign sc_a = (s_len == CW'(SC_A));
   assign sc_b = (s_len == CW'(SC_B));

   always_comb begin
      int t;
      frame_class_t c;
      t = int'(r_len);
      c = '{err: 1'b1, spd: SPD_NONE, fast: 1'b0};
      if (!tmo) begin
         if (hit_hi) begin
            if (t >= T50 && t <= T43) c = '{err: 1'b0, spd: SPD_SINGLE, fast: 1'b1};
         end else if (hit_mid) begin
            if (t >= T50 && t <= T2)        c = '{err: 1'b0, spd: SPD_SINGLE, fast: 1'b0};
            else if (t >= T100 && t <= T86) c = '{err: 1'b0, spd: SPD_DOUBLE, fast: 1'b1};
         end else if (hit_lo) begin
            if (t >= T100 && t <= T50)       c = '{err: 1'b0, spd: SPD_DOUBLE, fast: 1'b0};
            else if (t >= T200 && t <= T172) c = '{err: 1'b0, spd: SPD_QUAD, fast: 1'b1};
         end
         if (!c.err) begin
            if (c.spd == SPD_SINGLE) begin
               if (!(sc_a || sc_b)) c = '{err: 1'b1, spd: SPD_NONE, fast: 1'b0};
            end else if (!sc_a) begin
               c = '{err: 1'b1, spd: SPD_NONE, fast: 1'b0};
            end
         end
      end
      res = c;
   end

endmodule

// File: rtl/spd_autodet_lock.sv
module spd_autodet_lock
   import spd_autodet_pkg::*;
#(
   parameter int LOCK_N = 4,
   parameter int DROP_N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         done,
   input  logic         idle,
   input  frame_class_t res,
   output logic         locked,
   output logic         clk_err,
   output logic [1:0]   speed,
   output logic         ratio_fast
);

   localparam int RW = $clog2(LOCK_N + 1);
   localparam int MW = $clog2(DROP_N + 1);

   logic          locked_r, err_r;
   speed_e        cand_spd;
   logic          cand_fast;
   logic [RW-1:0] run;
   logic [MW-1:0] miss;
   logic          same;

   assign same = (res.spd == cand_spd) && (res.fast == cand_fast);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_r  <= 1'b0;
         err_r     <= 1'b0;
         cand_spd  <= SPD_NONE;
         cand_fast <= 1'b0;
         run       <= '0;
         miss      <= '0;
      end else if (idle) begin
         locked_r  <= 1'b0;
         err_r     <= 1'b0;
         cand_spd  <= SPD_NONE;
         cand_fast <= 1'b0;
         run       <= '0;
         miss      <= '0;
      end else if (done) begin
         if (res.err) begin
            err_r    <= 1'b1;
            locked_r <= 1'b0;
            run      <= '0;
            miss     <= '0;
         end else begin
            err_r <= 1'b0;
            if (!locked_r) begin
               if (run != '0 && same) begin
                  run <= run + RW'(1);
                  if (run == RW'(LOCK_N - 1)) locked_r <= 1'b1;
               end else begin
                  cand_spd  <= res.spd;
                  cand_fast <= res.fast;
                  run       <= RW'(1);
               end
            end else if (same) begin
               miss <= '0;
            end else if (miss == MW'(DROP_N - 1)) begin
               locked_r  <= 1'b0;
               cand_spd  <= res.spd;
               cand_fast <= res.fast;
               run       <= RW'(1);
               miss      <= '0;
            end else begin
               miss <= miss + MW'(1);
            end
         end
      end
   end

   assign locked     = locked_r;
   assign clk_err    = err_r;
   assign speed      = locked_r ? cand_spd : SPD_NONE;
   assign ratio_fast = locked_r & cand_fast;

   // R7
   lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_r) |-> $past(done) && !$past(res.err));

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && !idle) |=> $stable({locked_r, err_r, cand_spd, cand_fast}));

   // R11
   err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(locked_r && err_r));

   // R5
   err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_r) |-> $past(done) && $past(res.err));

endmodule

// File: rtl/spd_autodet.sv
module spd_autodet
   import spd_autodet_pkg::*;
#(
   parameter int BASE_RATIO = 768,
   parameter int REF_KHZ    = 3200,
   parameter int TOL        = 2,
   parameter int LOCK_N     = 4,
   parameter int DROP_N     = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       lrck,
   input  logic       sclk,
   input  logic       ref_tick,
   output logic [1:0] speed,
   output logic       ratio_fast,
   output logic       locked,
   output logic       clk_err
);

   localparam int TMO_CYC = 2 * BASE_RATIO;
   localparam int CW      = $clog2(TMO_CYC + 1);

   generate
      if (BASE_RATIO % 8 != 0) begin : g_bad_ratio
         $error("BASE_RATIO must divide by 8");
      end
      if (LOCK_N < 2) begin : g_bad_lock
         $error("LOCK_N must be at least 2");
      end
      if (DROP_N < 1) begin : g_bad_drop
         $error("DROP_N must be at least 1");
      end
      if (REF_KHZ / 200 <= TOL) begin : g_bad_ref
         $error("REF_KHZ too low to separate bands");
      end
   endgenerate

   logic          done, tmo, idle;
   logic [CW-1:0] m_len, s_len, r_len;
   frame_class_t  res;

   spd_autodet_meas #(.TMO_CYC(TMO_CYC), .CW(CW)) u_meas (
      .clk      (clk),
      .rst_n    (rst_n),
      .slave_req(mode == 2'b11),
      .lrck     (lrck),
      .sclk     (sclk),
      .ref_tick (ref_tick),
      .done     (done),
      .tmo      (tmo),
      .idle     (idle),
      .m_len    (m_len),
      .s_len    (s_len),
      .r_len    (r_len)
   );

   spd_autodet_class #(.CW(CW), .BASE_RATIO(BASE_RATIO), .REF_KHZ(REF_KHZ), .TOL(TOL)) u_class (
      .m_len(m_len),
      .s_len(s_len),
      .r_len(r_len),
      .tmo  (tmo),
      .res  (res)
   );

   spd_autodet_lock #(.LOCK_N(LOCK_N), .DROP_N(DROP_N)) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .done      (done),
      .idle      (idle),
      .res       (res),
      .locked    (locked),
      .clk_err   (clk_err),
      .speed     (speed),
      .ratio_fast(ratio_fast)
   );

endmodule

// File: tb/spd_autodet_test.sv
module spd_autodet_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       lrck = 1'b0, sclk = 1'b0, ref_tick = 1'b0;
   logic [1:0] speed;
   logic       ratio_fast, locked, clk_err;

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   spd_autodet uut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .lrck(lrck), .sclk(sclk),
      .ref_tick(ref_tick), .speed(speed), .ratio_fast(ratio_fast),
      .locked(locked), .clk_err(clk_err)
   );

   // stimulus generator: frame ratio, bit clocks per frame, reference divider
   int nx_ratio = 768, nx_sclk = 64, nx_ref = 11;
   int cu_ratio = 768, cu_sclk = 64, cu_ref = 11;
   int ph = 0, rc = 0, wraps = 0;

   always @(negedge clk) begin
      if (ph == 0) begin
         cu_ratio = nx_ratio; cu_sclk = nx_sclk; cu_ref = nx_ref;
      end
      if (cu_ratio == 0) begin
         lrck <= 1'b0; sclk <= 1'b0;
      end else begin
         int q;
         q = (ph * 2 * cu_sclk) / cu_ratio;
         lrck <= (ph < cu_ratio / 2);
         sclk <= q[0];
         ph = ph + 1;
         if (ph >= cu_ratio) begin ph = 0; wraps = wraps + 1; end
      end
      ref_tick <= (rc == 0);
      rc = rc + 1;
      if (rc >= cu_ref) rc = 0;
   end

   // behavioural reference model
   function automatic logic [3:0] classify(int len, int sl, int t, bit tm);
      logic [3:0] r;   // {err, spd[1:0], fast}
      r = 4'b1000;
      if (tm) return r;
      if (len >= 766 && len <= 770) begin
         if (t >= 64 && t <= 74) r = 4'b0011;
      end else if (len >= 382 && len <= 386) begin
         if (t >= 64 && t <= 1600) r = 4'b0010;
         else if (t >= 32 && t <= 37) r = 4'b0101;
      end else if (len >= 190 && len <= 194) begin
         if (t >= 32 && t <= 64) r = 4'b0100;
         else if (t >= 16 && t <= 18) r = 4'b0111;
      end
      if (!r[3]) begin
         if (r[2:1] == 2'b01) begin
            if (sl != 48 && sl != 64) r = 4'b1000;
         end else if (sl != 48) r = 4'b1000;
      end
      return r;
   endfunction

   bit pl, ps, armed, m_locked, m_err, c_fast;
   logic [1:0] c_spd;
   int m, sc, rcn, m_run, m_miss;
   logic [4:0] d1, d2, d3;

   always @(posedge clk) begin
      if (!rst_n) begin
         pl = 0; ps = 0; armed = 0; m = 0; sc = 0; rcn = 0;
         m_locked = 0; m_err = 0; c_spd = 0; c_fast = 0; m_run = 0; m_miss = 0;
         d1 = 0; d2 = 0; d3 = 0;
      end else begin
         bit rl, rs, have, tm;
         int len, sl, t;
         rl = lrck && !pl; rs = sclk && !ps; pl = lrck; ps = sclk;
         have = 0; tm = 0; len = 0; sl = 0; t = 0;
         if (mode != 2'b11) begin
            armed = 0; m = 0; sc = 0; rcn = 0;
            m_locked = 0; m_err = 0; c_spd = 0; c_fast = 0; m_run = 0; m_miss = 0;
         end else begin
            if (rl) begin
               if (armed) begin have = 1; len = m; sl = sc; t = rcn; end
               armed = 1; m = 1; sc = int'(rs); rcn = int'(ref_tick);
            end else if (armed) begin
               if (m == 1536) begin
                  have = 1; tm = 1; m = 1; sc = int'(rs); rcn = int'(ref_tick);
               end else begin
                  m = m + 1; sc = sc + int'(rs); rcn = rcn + int'(ref_tick);
               end
            end
            if (have) begin
               logic [3:0] r;
               r = classify(len, sl, t, tm);
               if (r[3]) begin
                  m_err = 1; m_locked = 0; m_run = 0; m_miss = 0;
               end else begin
                  bit same;
                  m_err = 0;
                  same = (r[2:1] == c_spd) && (r[0] == c_fast);
                  if (!m_locked) begin
                     if (m_run != 0 && same) begin
                        m_run = m_run + 1;
                        if (m_run == 4) m_locked = 1;
                     end else begin
                        c_spd = r[2:1]; c_fast = r[0]; m_run = 1;
                     end
                  end else if (same) m_miss = 0;
                  else begin
                     m_miss = m_miss + 1;
                     if (m_miss == 2) begin
                        m_locked = 0; c_spd = r[2:1]; c_fast = r[0]; m_run = 1; m_miss = 0;
                     end
                  end
               end
            end
         end
         d3 = d2; d2 = d1;
         d1 = {m_locked, m_locked ? c_spd : 2'b00, m_locked & c_fast, m_err};
      end
   end

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         checks++;
         if ({locked, speed, ratio_fast, clk_err} !== d3) begin
            fails++;
            $display("FAIL R7 model compare t=%0t actual=%b expected=%b",
                     $time, {locked, speed, ratio_fast, clk_err}, d3);
         end
      end
   end

   task automatic expect_out(string req, logic l, logic [1:0] sp, logic f, logic e);
      checks++;
      if ({locked, speed, ratio_fast, clk_err} !== {l, sp, f, e}) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b", req,
                  {locked, speed, ratio_fast, clk_err}, {l, sp, f, e});
      end
   endtask

   task automatic periods(int n);
      int w0;
      w0 = wraps;
      while (wraps < w0 + n) @(negedge clk);
      repeat (6) @(negedge clk);
   endtask

   task automatic setcfg(int r, int s, int k);
      nx_ratio = r; nx_sclk = s; nx_ref = k;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      expect_out("R1 reset state", 0, 2'b00, 0, 0);
      periods(5);
      expect_out("R1 mode 00 idle", 0, 2'b00, 0, 0);
      mode = 2'b11;
      periods(3);
      expect_out("R10 first edge arms only", 0, 2'b00, 0, 0);
      periods(3);
      expect_out("R2 R7 768 single fast lock", 1, 2'b01, 1, 0);
      setcfg(768, 48, 11); periods(3);
      expect_out("R6 single with 48 bit clocks", 1, 2'b01, 1, 0);
      setcfg(384, 64, 5); periods(2);
      expect_out("R8 one mismatch holds lock", 1, 2'b01, 1, 0);
      periods(1);
      expect_out("R8 two mismatches drop lock", 0, 2'b00, 0, 0);
      periods(4);
      expect_out("R3 384 single slow", 1, 2'b01, 0, 0);
      setcfg(384, 48, 6); periods(6);
      expect_out("R3 384 at band edge 64", 1, 2'b01, 0, 0);
      setcfg(384, 48, 11); periods(7);
      expect_out("R3 384 double fast", 1, 2'b10, 1, 0);
      setcfg(384, 48, 8); periods(2);
      expect_out("R3 384 between bands", 0, 2'b00, 0, 1);
      setcfg(192, 48, 4); periods(6);
      expect_out("R4 192 double slow", 1, 2'b10, 0, 0);
      setcfg(192, 48, 3); periods(3);
      expect_out("R4 192 at band edge 64", 1, 2'b10, 0, 0);
      setcfg(192, 48, 11); periods(7);
      expect_out("R4 192 quad fast", 1, 2'b11, 1, 0);
      setcfg(192, 64, 11); periods(2);
      expect_out("R6 quad with 64 bit clocks", 0, 2'b00, 0, 1);
      setcfg(192, 48, 8); periods(2);
      expect_out("R4 192 between bands", 0, 2'b00, 0, 1);
      setcfg(96, 48, 2); periods(3);
      expect_out("R5 ratio 96 rejected", 0, 2'b00, 0, 1);
      setcfg(770, 48, 11); periods(6);
      expect_out("R2 ratio 770 within window", 1, 2'b01, 1, 0);
      setcfg(771, 48, 11); periods(2);
      expect_out("R5 ratio 771 outside window", 0, 2'b00, 0, 1);
      setcfg(770, 48, 11); periods(2);
      expect_out("R11 good frame clears error", 0, 2'b00, 0, 0);
      setcfg(0, 48, 11);
      repeat (2600) @(negedge clk);
      expect_out("R9 frame clock stopped", 0, 2'b00, 0, 1);
      setcfg(768, 64, 11);
      mode = 2'b00;
      repeat (5) @(negedge clk);
      expect_out("R1 leaving slave mode", 0, 2'b00, 0, 0);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         fails++;
         $display("FAIL R9 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule